// File: doc/BRIEF.md
# Five-Stage Half-Band Decimation Chain

This block lowers the sample rate of a 16-bit signed baseband stream by a factor of 32. It does so with five half-band FIR stages in series, each of which keeps one output for every two input samples. A typical use is after a coarse integrator-comb decimator: a stream arriving at 7.68 MHz leaves at 240 kHz, and the 24 kHz band of interest passes. Aliasing in the transition band is tolerated.

Each stage uses the half-band shape of its filter. Every second coefficient is zero, so those products are skipped. The taps are symmetric, so mirrored samples are added before they are multiplied. The centre coefficient is one half and is applied as a shift, not a multiplier. Stages one to four have seven taps and the last stage has eleven. Each stage rounds its result and saturates it to 16 bits before the next stage sees it. Every stage raises its own valid strobe, and the strobe of the last stage is the chain output strobe.

Top module: `hbDecimChain`

## Requirements
- R1: While reset is high and on the first cycle after it, `outValid` is 0 and `outData` is 0. Every stage's delay line and phase are cleared.
- R2: A stage accepts a sample only in a cycle where its input valid is high. It emits a result on the 2nd, 4th, 6th... sample it has accepted since reset. The chain therefore emits one result per 32 accepted input samples.
- R3: Stages one to four compute y = x[n-3]/2 + c1*(x[n-2]+x[n-4]) + c3*(x[n]+x[n-6]), where x[n] is the sample accepted on the emitting cycle. In Q16 the coefficients are c1 = 18432 and c3 = -2048.
- R4: Stage five computes y = x[n-5]/2 + c1*(x[n-4]+x[n-6]) + c3*(x[n-2]+x[n-8]) + c5*(x[n]+x[n-10]). In Q16 the coefficients are c1 = 19200, c3 = -3200 and c5 = 384.
- R5: A stage whose rounded result is above 32767 emits 32767. A stage whose rounded result is below -32768 emits -32768.
- R6: A stage forms its full-precision Q16 sum, adds 2^15, and then takes the floor after dividing by 2^16.
- R7: Between output strobes, `outData` keeps the last value that was emitted.
- R8: A constant input held long enough to fill every stage comes out unchanged, because the DC gain of each stage is exactly one.
- R9: Each stage registers its result. That result and its strobe appear one clock after the input sample that completes the pair, and the strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inData | input | 16 | Signed input sample |
| outValid | output | 1 | Output sample strobe, one cycle long |
| outData | output | 16 | Signed decimated sample, held between strobes |

## Verification
When input valid is high on back-to-back cycles, a stage shifts in a new sample and registers a result on the same edge. On the next edge the stage after it takes in that result while the earlier stage takes in yet another sample. So shifting and emitting overlap in the same cycle, and the handover between stages falls on the same cycle as fresh input. The bench provokes both with continuous bursts and with randomly gapped valid. It also uses full-scale random data, so saturation and rounding happen during these overlaps. A behavioural model updated every clock judges the strobe and data on every cycle.

// File: rtl/hbPkg.sv
package hbPkg;
  localparam int COEF_FRAC = 16;

  typedef struct packed {
    logic shiftEn;
    logic computeEn;
  } hbStrobe_t;

  // Q16 coefficient at odd distance k from the centre tap
  function automatic int hbCoef(input int nTaps, input int k);
    int c;
    c = 0;
    if (nTaps == 7) begin
      if (k == 1) c = 18432;
      else if (k == 3) c = -2048;
    end else if (nTaps == 11) begin
      if (k == 1) c = 19200;
      else if (k == 3) c = -3200;
      else if (k == 5) c = 384;
    end
    return c;
  endfunction
endpackage

// File: rtl/hbCtrl.sv
module hbCtrl (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output hbPkg::hbStrobe_t  strobe,
  output logic              outValid
);
  logic phase;

  always_comb begin
    strobe.shiftEn   = inValid;
    strobe.computeEn = inValid & phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      if (inValid) phase <= ~phase;
      outValid <= inValid & phase;
    end
  end
endmodule

// File: rtl/hbData.sv
module hbData #(
  parameter int DATA_W = 16,
  parameter int N_TAPS = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  hbPkg::hbStrobe_t         strobe,
  input  logic signed [DATA_W-1:0] xIn,
  output logic signed [DATA_W-1:0] yOut
);
  localparam int CTR   = (N_TAPS - 1) / 2;
  localparam int SUM_W = DATA_W + 1;
  localparam int ACC_W = DATA_W + hbPkg::COEF_FRAC + 4;
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (hbPkg::COEF_FRAC - 1);
  localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO   = -(ACC_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0] dly [N_TAPS-1];
  logic signed [DATA_W-1:0] win [N_TAPS];
  logic signed [SUM_W-1:0]  preSum;
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;
  logic signed [DATA_W-1:0] satVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_TAPS - 1; i++) dly[i] <= '0;
    end else if (strobe.shiftEn) begin
      dly[0] <= xIn;
      for (int i = 1; i < N_TAPS - 1; i++) dly[i] <= dly[i-1];
    end
  end

  always_comb begin
    win[0] = xIn;
    for (int i = 1; i < N_TAPS; i++) win[i] = dly[i-1];
  end

  // centre tap as shift, symmetric pairs pre-added, zero taps skipped
  always_comb begin
    preSum = '0;
    acc = ACC_W'(win[CTR]) <<< (hbPkg::COEF_FRAC - 1);
    for (int k = 1; k <= CTR; k += 2) begin
      preSum = SUM_W'(win[CTR-k]) + SUM_W'(win[CTR+k]);
      acc = acc + ACC_W'(preSum) * ACC_W'(hbPkg::hbCoef(N_TAPS, k));
    end
    scaled = (acc + HALF_LSB) >>> hbPkg::COEF_FRAC;
    if (scaled > SAT_HI)      satVal = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) satVal = SAT_LO[DATA_W-1:0];
    else                      satVal = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) yOut <= '0;
    else if (strobe.computeEn) yOut <= satVal;
  end
endmodule

// File: rtl/hbStage.sv
module hbStage #(
  parameter int DATA_W = 16,
  parameter int N_TAPS = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outData
);
  hbPkg::hbStrobe_t strobe;

  hbCtrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  hbData #(.DATA_W(DATA_W), .N_TAPS(N_TAPS)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe),
    .xIn(inData), .yOut(outData)
  );
endmodule

// File: rtl/hbDecimChain.sv
module hbDecimChain #(
  parameter int DATA_W    = 16,
  parameter int N_STAGES  = 5,
  parameter int BASE_TAPS = 7,
  parameter int LAST_TAPS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [N_STAGES:0]        stgValid;
  logic signed [DATA_W-1:0] stgData [N_STAGES+1];

  assign stgValid[0] = inValid;
  assign stgData[0]  = inData;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    localparam int TAPS = (s == N_STAGES - 1) ? LAST_TAPS : BASE_TAPS;
    hbStage #(.DATA_W(DATA_W), .N_TAPS(TAPS)) u_stage (
      .clk(clk), .rst(rst),
      .inValid(stgValid[s]), .inData(stgData[s]),
      .outValid(stgValid[s+1]), .outData(stgData[s+1])
    );
  end

  assign outValid = stgValid[N_STAGES];
  assign outData  = stgData[N_STAGES];
endmodule

// File: rtl/hbDecimChainChk.sv
module hbDecimChainChk #(
  parameter int DATA_W   = 16,
  parameter int N_STAGES = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [N_STAGES:0] stgValid,
  input logic              outValid,
  input logic [DATA_W-1:0] outData
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (!outValid && outData == '0))
    else $error("reset state violated");

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst) outValid |=> !outValid)
    else $error("output strobe longer than one cycle");

  p_hold_r7: assert property (@(posedge clk) disable iff (rst) !outValid |-> $stable(outData))
    else $error("output changed without strobe");

  for (genvar s = 0; s < N_STAGES; s++) begin : g_chk
    p_chain_r2: assert property (@(posedge clk) disable iff (rst)
                                 stgValid[s+1] |-> $past(stgValid[s]))
      else $error("stage strobe without prior input");
    p_decim_r2: assert property (@(posedge clk) disable iff (rst)
                                 stgValid[s+1] |=> !stgValid[s+1])
      else $error("stage emitted on consecutive cycles");
  end
endmodule

bind hbDecimChain hbDecimChainChk #(.DATA_W(DATA_W), .N_STAGES(N_STAGES)) u_chk (
  .clk(clk), .rst(rst), .stgValid(stgValid),
  .outValid(outValid), .outData(outData)
);

// File: tb/sim_hbDecimChain.sv
module sim_hbDecimChain;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        outValid;
  logic [15:0] outData;

  int nTests = 0;
  int nFail  = 0;
  int hist [5][11];
  bit ph [5];
  bit mv [5];
  int md [5];
  int lastOut = 0;
  int satSeen = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hbDecimChain u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  function automatic int coefB(int s, int k);
    if (s == 4) return (k == 1) ? 19200 : (k == 3) ? -3200 : (k == 5) ? 384 : 0;
    return (k == 1) ? 18432 : (k == 3) ? -2048 : 0;
  endfunction

  function automatic int calc(int s);
    int n = (s == 4) ? 11 : 7;
    int c = (n - 1) / 2;
    longint acc = longint'(hist[s][c]) * 32768;
    for (int k = 1; k <= c; k += 2)
      acc += longint'(coefB(s, k)) * longint'(hist[s][c-k] + hist[s][c+k]);
    acc = (acc + 32768) >>> 16;
    if (acc > 32767) begin acc = 32767; satSeen++; end
    if (acc < -32768) begin acc = -32768; satSeen++; end
    return int'(acc);
  endfunction

  task automatic modelReset();
    for (int s = 0; s < 5; s++) begin
      ph[s] = 0; mv[s] = 0; md[s] = 0;
      for (int i = 0; i < 11; i++) hist[s][i] = 0;
    end
    lastOut = 0;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare state after last edge, then drive and advance model to next edge
  task automatic step(bit v, int d);
    @(negedge clk);
    check(outValid == mv[4], "R2 R9 strobe", int'(outValid), int'(mv[4]));
    if (mv[4]) begin
      check($signed(outData) == md[4], "R3 R4 R5 R6 data", int'($signed(outData)), md[4]);
      lastOut = md[4];
    end else begin
      check($signed(outData) == lastOut, "R7 hold", int'($signed(outData)), lastOut);
    end
    inValid = v;
    inData  = 16'(d);
    for (int s = 4; s >= 0; s--) begin
      bit iv = (s == 0) ? v : mv[s-1];
      int id = (s == 0) ? d : md[s-1];
      bit nv = 0;
      if (iv) begin
        for (int i = 10; i > 0; i--) hist[s][i] = hist[s][i-1];
        hist[s][0] = id;
        if (ph[s]) begin md[s] = calc(s); nv = 1; end
        ph[s] = ~ph[s];
      end
      mv[s] = nv;
    end
  endtask

  function automatic int fullScale();
    return ($urandom_range(0, 1) == 1) ? 32767 : -32768;
  endfunction

  initial begin
    int outCount;
    modelReset();
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outData == 16'd0, "R1 reset", int'(outData), 0);
    rst = 1'b0;
    step(0, 0);
    check(outValid == 1'b0 && outData == 16'd0, "R1 after reset", int'(outData), 0);

    // DC passes unchanged
    for (int i = 0; i < 32 * 40; i++) step(1, 1234);
    step(0, 0);
    check(lastOut == 1234 && $signed(outData) == 1234, "R8 dc gain", int'($signed(outData)), 1234);

    // full-scale random, continuous valid
    for (int i = 0; i < 32 * 60; i++) step(1, fullScale());
    check(satSeen > 0, "R5 saturation provoked", satSeen, 1);

    // moderate random data with gapped valid; count outputs per 32 accepted
    outCount = 0;
    for (int i = 0; i < 32 * 80; i++) begin
      step($urandom_range(0, 1) == 1, int'($urandom_range(0, 40000)) - 20000);
      if (mv[4]) outCount++;
    end
    for (int i = 0; i < 64; i++) step(0, 0);

    // exactly 64 accepted samples after a drain -> exactly 2 outputs
    outCount = 0;
    for (int i = 0; i < 64; i++) begin
      step(1, int'($urandom_range(0, 2000)) - 1000);
      if (mv[4]) outCount++;
    end
    for (int i = 0; i < 8; i++) begin
      step(0, 0);
      if (mv[4]) outCount++;
    end
    check(outCount == 2, "R2 decimation by 32", outCount, 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule